// File: doc/BRIEF.md
# Pre-adder input stage with selectable operand pipeline

This block sits at the front of a multiply-accumulate slice. It takes a 27-bit D operand and two wider operands, A (34 bits) and B (24 bits). Each of A and B enters from either a direct port or a cascade port from a neighbouring slice. Each then passes through an input pipeline of zero, one or two registers. A signed pre-adder forms D plus or minus one selected operand. An optional register holds the 28-bit result.

The depth of each input pipeline, the cascade-or-direct choice, the pre-adder operand and the presence of the result and mode registers are static parameters. A five-bit runtime mode word chooses, per operand, which register stage feeds the multiplier path. It also chooses whether the pre-adder adds or subtracts. Every register group has its own clock enable and its own synchronous active-low reset. The last register of each operand pipeline drives that operand's cascade output toward the next slice.

Top module: `preadd_input_stage`

## Requirements
- R1: With mode bit 3 at 0 the pre-adder result is D + X, and with bit 3 at 1 it is D − X. D and X are taken as 27-bit two's complement values, and the result is a 28-bit two's complement value that never overflows (0x3FFFFFF + 0x3FFFFFF gives 0x7FFFFFE).
- R2: The operand X is the low 27 bits of the multiplier-path A value when PRE_USE_B is 0. When PRE_USE_B is 1, X is the 24-bit multiplier-path B value sign-extended to 27 bits.
- R3: With A_DEPTH 2, the first A register loads the A source when ce_a1 is high, and the second loads the first when ce_a2 is high. a_mult_out shows the first register when mode bit 0 is 1 and the second register when mode bit 0 is 0.
- R4: The B pipeline follows the same rule as R3, using ce_b1, ce_b2 and mode bit 4.
- R5: With depth 1 only the second register exists; it loads the source under the second-stage enable, and the multiplier path shows the unregistered source while the selecting mode bit is 1. With depth 0 the multiplier path and cascade output follow the source in the same cycle.
- R6: a_casc_out and b_casc_out carry the last register of their pipeline (the source itself at depth 0), independent of the mode word.
- R7: A_FROM_CASC = 1 makes a_casc_in the A source, otherwise a_in; B_FROM_CASC does the same for b_casc_in and b_in.
- R8: With MODE_REG 1 the mode word acts one cycle after it is loaded under ce_mode. With MODE_REG 0 it acts in the same cycle.
- R9: With AD_REG 1, ad_out loads the pre-adder result when ce_ad is high and appears one cycle later. With AD_REG 0, ad_out is the pre-adder result in the same cycle.
- R10: Each reset (rst_a_n, rst_b_n, rst_mode_n, rst_ad_n) is synchronous and active low. It wins over its enable and clears only its own registers to zero.
- R11: A register whose enable is low keeps its value while its reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| d_in | input | 27 | D operand of the pre-adder |
| a_in | input | 34 | Direct A operand |
| a_casc_in | input | 34 | A operand from the previous slice |
| b_in | input | 24 | Direct B operand |
| b_casc_in | input | 24 | B operand from the previous slice |
| mode_in | input | 5 | Mode word: bit 0 A tap, bit 3 subtract, bit 4 B tap |
| ce_a1 | input | 1 | Enable, first A register |
| ce_a2 | input | 1 | Enable, second A register |
| ce_b1 | input | 1 | Enable, first B register |
| ce_b2 | input | 1 | Enable, second B register |
| ce_mode | input | 1 | Enable, mode register |
| ce_ad | input | 1 | Enable, pre-adder result register |
| rst_a_n | input | 1 | Synchronous reset of the A registers, active low |
| rst_b_n | input | 1 | Synchronous reset of the B registers, active low |
| rst_mode_n | input | 1 | Synchronous reset of the mode register, active low |
| rst_ad_n | input | 1 | Synchronous reset of the result register, active low |
| a_casc_out | output | 34 | Registered A toward the next slice |
| b_casc_out | output | 24 | Registered B toward the next slice |
| a_mult_out | output | 34 | A value selected for the multiplier |
| b_mult_out | output | 24 | B value selected for the multiplier |
| ad_out | output | 28 | Pre-adder result, sign-extended |

## Verification
Two instances run side by side on the same stimulus. One has deep pipelines, registered mode and result, and adds A. The other has a single A register, a combinational B path, unregistered mode and result, and adds B. Random operands with enables dropping at random separate the first and second register taps and expose any register that loads without its enable. Mode bits flipping every cycle separate registered from direct mode handling. Directed extreme operands (largest positive plus largest positive, most negative minus largest positive) show whether the extra result bit is present and whether subtraction is signed. A phase with all enables low, and one with resets pulsed one group at a time, show that each reset clears only its own registers.

// File: rtl/preadd_pkg.sv
// Package: shared widths and mode-word bit positions of the pre-adder input stage.
// Assumes: operand widths are at most 27 bits for B and at least 27 bits for A.
package preadd_pkg;
    localparam int unsigned PRE_W   = 27;  // pre-adder operand width
    localparam int unsigned MODE_W  = 5;   // runtime mode word width
    localparam int unsigned MB_A1   = 0;   // A tap: 1 = first register
    localparam int unsigned MB_SUB  = 3;   // 1 = subtract
    localparam int unsigned MB_B1   = 4;   // B tap: 1 = first register

    typedef enum logic {
        PRE_ADD = 1'b0,
        PRE_SUB = 1'b1
    } pre_op_e;
endpackage

// File: rtl/opnd_pipe.sv
// Module: operand input pipeline of depth 0, 1 or 2 with a runtime tap choice.
// Assumes: DEPTH is 0, 1 or 2; reset is synchronous, active low, over the enables.
module opnd_pipe #(
    parameter int W     = 34,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce1,
    input  logic         ce2,
    input  logic         use_first,
    input  logic [W-1:0] src,
    output logic [W-1:0] casc,
    output logic [W-1:0] tap
);
    generate
        if (DEPTH == 2) begin : g_two
            logic [W-1:0] st1;
            logic [W-1:0] st2;

            // First stage: capture the operand source.
            always_ff @(posedge clk) begin
                if (!rst_n)   st1 <= '0;
                else if (ce1) st1 <= src;
            end

            // Second stage: capture the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n)   st2 <= '0;
                else if (ce2) st2 <= st1;
            end

            assign tap  = use_first ? st1 : st2;
            assign casc = st2;
        end else if (DEPTH == 1) begin : g_one
            logic [W-1:0] st2;
            logic         unused_ce1;
            assign unused_ce1 = ce1;

            // Single stage: capture the operand source.
            always_ff @(posedge clk) begin
                if (!rst_n)   st2 <= '0;
                else if (ce2) st2 <= src;
            end

            assign tap  = use_first ? src : st2;
            assign casc = st2;
        end else begin : g_none
            logic [4:0] unused_ctl;
            assign unused_ctl = {clk, rst_n, ce1, ce2, use_first};
            assign tap  = src;
            assign casc = src;
        end
    endgenerate
endmodule

// File: rtl/mode_reg.sv
// Module: optional register for the runtime mode word.
// Assumes: EN is 0 (mode used directly) or 1 (registered, one cycle of latency).
module mode_reg #(
    parameter int W  = 5,
    parameter int EN = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] mode_in,
    output logic [W-1:0] mode_q
);
    generate
        if (EN != 0) begin : g_reg
            logic [W-1:0] q;

            // Hold the mode word under its own enable and reset.
            always_ff @(posedge clk) begin
                if (!rst_n)  q <= '0;
                else if (ce) q <= mode_in;
            end

            assign mode_q = q;
        end else begin : g_wire
            logic [2:0] unused_ctl;
            assign unused_ctl = {clk, rst_n, ce};
            assign mode_q = mode_in;
        end
    endgenerate
endmodule

// File: rtl/preadder.sv
// Module: signed add/subtract of two W-bit operands giving W+1 bits, optional output register.
// Assumes: both operands are two's complement; REG is 0 or 1.
module preadder #(
    parameter int W   = 27,
    parameter int REG = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  preadd_pkg::pre_op_e  op,
    input  logic [W-1:0]         d,
    input  logic [W-1:0]         x,
    output logic [W:0]           ad
);
    localparam int RW = W + 1;

    logic signed [RW-1:0] d_ext;
    logic signed [RW-1:0] x_ext;
    logic        [RW-1:0] sum;

    // Widen both operands by one sign bit so the result cannot overflow.
    always_comb begin
        d_ext = RW'($signed(d));
        x_ext = RW'($signed(x));
        if (op == preadd_pkg::PRE_SUB) sum = d_ext - x_ext;
        else                           sum = d_ext + x_ext;
    end

    generate
        if (REG != 0) begin : g_reg
            logic [RW-1:0] q;

            // Result pipeline register with dedicated enable and reset.
            always_ff @(posedge clk) begin
                if (!rst_n)  q <= '0;
                else if (ce) q <= sum;
            end

            assign ad = q;
        end else begin : g_wire
            logic [2:0] unused_ctl;
            assign unused_ctl = {clk, rst_n, ce};
            assign ad = sum;
        end
    endgenerate
endmodule

// File: rtl/preadd_input_stage.sv
// Module: input stage of a multiply-accumulate slice: A/B source muxes, A/B
// input pipelines, mode register and pre-adder with optional result register.
// Assumes: A_W >= PRE_W, B_W <= PRE_W, depths 0..2, all resets synchronous active low.
module preadd_input_stage #(
    parameter int A_W         = 34,
    parameter int B_W         = 24,
    parameter int D_W         = preadd_pkg::PRE_W,
    parameter int A_DEPTH     = 2,
    parameter int B_DEPTH     = 2,
    parameter int A_FROM_CASC = 0,
    parameter int B_FROM_CASC = 1,
    parameter int PRE_USE_B   = 0,
    parameter int MODE_REG    = 1,
    parameter int AD_REG      = 1
) (
    input  logic                          clk,
    input  logic [D_W-1:0]                d_in,
    input  logic [A_W-1:0]                a_in,
    input  logic [A_W-1:0]                a_casc_in,
    input  logic [B_W-1:0]                b_in,
    input  logic [B_W-1:0]                b_casc_in,
    input  logic [preadd_pkg::MODE_W-1:0] mode_in,
    input  logic                          ce_a1,
    input  logic                          ce_a2,
    input  logic                          ce_b1,
    input  logic                          ce_b2,
    input  logic                          ce_mode,
    input  logic                          ce_ad,
    input  logic                          rst_a_n,
    input  logic                          rst_b_n,
    input  logic                          rst_mode_n,
    input  logic                          rst_ad_n,
    output logic [A_W-1:0]                a_casc_out,
    output logic [B_W-1:0]                b_casc_out,
    output logic [A_W-1:0]                a_mult_out,
    output logic [B_W-1:0]                b_mult_out,
    output logic [D_W:0]                  ad_out
);
    import preadd_pkg::*;

    logic [MODE_W-1:0] mode_q;
    logic [A_W-1:0]    a_src;
    logic [B_W-1:0]    b_src;
    logic [A_W-1:0]    a_tap;
    logic [B_W-1:0]    b_tap;
    logic [D_W-1:0]    pre_x;
    pre_op_e           pre_sub;
    logic [1:0]        unused_mode;

    assign unused_mode = mode_q[2:1];

    // Static choice between direct and cascaded operand sources.
    assign a_src = (A_FROM_CASC != 0) ? a_casc_in : a_in;
    assign b_src = (B_FROM_CASC != 0) ? b_casc_in : b_in;

    mode_reg #(.W(MODE_W), .EN(MODE_REG)) u_mode (
        .clk     (clk),
        .rst_n   (rst_mode_n),
        .ce      (ce_mode),
        .mode_in (mode_in),
        .mode_q  (mode_q)
    );

    opnd_pipe #(.W(A_W), .DEPTH(A_DEPTH)) u_a_pipe (
        .clk       (clk),
        .rst_n     (rst_a_n),
        .ce1       (ce_a1),
        .ce2       (ce_a2),
        .use_first (mode_q[MB_A1]),
        .src       (a_src),
        .casc      (a_casc_out),
        .tap       (a_tap)
    );

    opnd_pipe #(.W(B_W), .DEPTH(B_DEPTH)) u_b_pipe (
        .clk       (clk),
        .rst_n     (rst_b_n),
        .ce1       (ce_b1),
        .ce2       (ce_b2),
        .use_first (mode_q[MB_B1]),
        .src       (b_src),
        .casc      (b_casc_out),
        .tap       (b_tap)
    );

    // Pick the pre-adder operand: low A bits or sign-extended B.
    generate
        if (PRE_USE_B != 0) begin : g_pre_b
            assign pre_x = D_W'($signed(b_tap));
        end else begin : g_pre_a
            assign pre_x = a_tap[D_W-1:0];
        end
    endgenerate

    assign pre_sub = mode_q[MB_SUB] ? PRE_SUB : PRE_ADD;

    preadder #(.W(D_W), .REG(AD_REG)) u_pre (
        .clk   (clk),
        .rst_n (rst_ad_n),
        .ce    (ce_ad),
        .op    (pre_sub),
        .d     (d_in),
        .x     (pre_x),
        .ad    (ad_out)
    );

    assign a_mult_out = a_tap;
    assign b_mult_out = b_tap;
endmodule

// File: rtl/preadd_input_stage_chk.sv
// Module: property checker for the pre-adder input stage, bound to the top.
// Assumes: it sees the top's ports plus the pre-adder operand and operation.
module preadd_input_stage_chk #(
    parameter int A_W         = 34,
    parameter int D_W         = 27,
    parameter int A_DEPTH     = 2,
    parameter int A_FROM_CASC = 0,
    parameter int AD_REG      = 1
) (
    input logic           clk,
    input logic           rst_a_n,
    input logic           rst_ad_n,
    input logic           ce_a1,
    input logic           ce_a2,
    input logic           ce_ad,
    input logic [A_W-1:0] a_in,
    input logic [A_W-1:0] a_casc_in,
    input logic [A_W-1:0] a_casc_out,
    input logic [D_W-1:0] d_in,
    input logic [D_W-1:0] pre_x,
    input logic           pre_sub,
    input logic [D_W:0]   ad_out
);
    logic [A_W-1:0] chk_a_src;
    logic [D_W:0]   chk_expect;

    // Independent view of the A source and of the signed pre-adder result.
    always_comb begin
        chk_a_src = (A_FROM_CASC != 0) ? a_casc_in : a_in;
        if (pre_sub) chk_expect = (D_W+1)'($signed(d_in)) - (D_W+1)'($signed(pre_x));
        else         chk_expect = (D_W+1)'($signed(d_in)) + (D_W+1)'($signed(pre_x));
    end

    generate
        if (AD_REG != 0) begin : g_ad
            assert_ad_reset_R10: assert property (@(posedge clk) disable iff (!rst_a_n)
                !rst_ad_n |=> ad_out == '0);
            assert_ad_hold_R11: assert property (@(posedge clk) disable iff (!rst_ad_n)
                !ce_ad |=> $stable(ad_out));
            assert_ad_capture_R9: assert property (@(posedge clk) disable iff (!rst_ad_n)
                ce_ad |=> ad_out == $past(chk_expect));
        end
        if (A_DEPTH == 2) begin : g_a2
            assert_a_chain_R3: assert property (@(posedge clk) disable iff (!rst_a_n)
                ce_a1 ##1 ce_a2 |=> a_casc_out == $past(chk_a_src, 2));
        end
        if (A_DEPTH >= 1) begin : g_a1
            assert_casc_hold_R6: assert property (@(posedge clk) disable iff (!rst_a_n)
                !ce_a2 |=> $stable(a_casc_out));
        end
    endgenerate
endmodule

bind preadd_input_stage preadd_input_stage_chk #(
    .A_W(A_W), .D_W(D_W), .A_DEPTH(A_DEPTH), .A_FROM_CASC(A_FROM_CASC), .AD_REG(AD_REG)
) chk_i (
    .clk        (clk),
    .rst_a_n    (rst_a_n),
    .rst_ad_n   (rst_ad_n),
    .ce_a1      (ce_a1),
    .ce_a2      (ce_a2),
    .ce_ad      (ce_ad),
    .a_in       (a_in),
    .a_casc_in  (a_casc_in),
    .a_casc_out (a_casc_out),
    .d_in       (d_in),
    .pre_x      (pre_x),
    .pre_sub    (pre_sub),
    .ad_out     (ad_out)
);

// File: tb/preadd_input_stage_tb_top.sv
`timescale 1ns/1ps
module preadd_input_stage_tb_top;
    localparam int NCFG = 2;
    localparam int ADEP [NCFG] = '{2, 1};
    localparam int BDEP [NCFG] = '{2, 0};
    localparam int ACAS [NCFG] = '{0, 1};
    localparam int BCAS [NCFG] = '{1, 0};
    localparam int PUB  [NCFG] = '{0, 1};
    localparam int MREG [NCFG] = '{1, 0};
    localparam int AREG [NCFG] = '{1, 0};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic [26:0] d_in = '0;
    logic [33:0] a_in = '0, a_casc_in = '0;
    logic [23:0] b_in = '0, b_casc_in = '0;
    logic [4:0]  mode_in = '0;
    logic ce_a1 = 0, ce_a2 = 0, ce_b1 = 0, ce_b2 = 0, ce_mode = 0, ce_ad = 0;
    logic rst_a_n = 0, rst_b_n = 0, rst_mode_n = 0, rst_ad_n = 0;

    logic [33:0] o_acas [NCFG];
    logic [23:0] o_bcas [NCFG];
    logic [33:0] o_amul [NCFG];
    logic [23:0] o_bmul [NCFG];
    logic [27:0] o_ad   [NCFG];

    preadd_input_stage dut_i (
        .clk(clk), .d_in(d_in), .a_in(a_in), .a_casc_in(a_casc_in), .b_in(b_in),
        .b_casc_in(b_casc_in), .mode_in(mode_in), .ce_a1(ce_a1), .ce_a2(ce_a2),
        .ce_b1(ce_b1), .ce_b2(ce_b2), .ce_mode(ce_mode), .ce_ad(ce_ad),
        .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .rst_mode_n(rst_mode_n), .rst_ad_n(rst_ad_n),
        .a_casc_out(o_acas[0]), .b_casc_out(o_bcas[0]), .a_mult_out(o_amul[0]),
        .b_mult_out(o_bmul[0]), .ad_out(o_ad[0]));

    preadd_input_stage #(
        .A_DEPTH(1), .B_DEPTH(0), .A_FROM_CASC(1), .B_FROM_CASC(0),
        .PRE_USE_B(1), .MODE_REG(0), .AD_REG(0)
    ) dut_alt_i (
        .clk(clk), .d_in(d_in), .a_in(a_in), .a_casc_in(a_casc_in), .b_in(b_in),
        .b_casc_in(b_casc_in), .mode_in(mode_in), .ce_a1(ce_a1), .ce_a2(ce_a2),
        .ce_b1(ce_b1), .ce_b2(ce_b2), .ce_mode(ce_mode), .ce_ad(ce_ad),
        .rst_a_n(rst_a_n), .rst_b_n(rst_b_n), .rst_mode_n(rst_mode_n), .rst_ad_n(rst_ad_n),
        .a_casc_out(o_acas[1]), .b_casc_out(o_bcas[1]), .a_mult_out(o_amul[1]),
        .b_mult_out(o_bmul[1]), .ad_out(o_ad[1]));

    // Behavioural reference state, one set per configuration.
    logic [33:0] ma1 [NCFG], ma2 [NCFG];
    logic [23:0] mb1 [NCFG], mb2 [NCFG];
    logic [4:0]  mmode [NCFG];
    logic [27:0] mad [NCFG];

    int    n_vec = 0, n_bad = 0;
    bit    done  = 0;
    string phase = "R10";

    function automatic logic [4:0] m_mode(int k);
        return (MREG[k] != 0) ? mmode[k] : mode_in;
    endfunction
    function automatic logic [33:0] m_asrc(int k);
        return (ACAS[k] != 0) ? a_casc_in : a_in;
    endfunction
    function automatic logic [23:0] m_bsrc(int k);
        return (BCAS[k] != 0) ? b_casc_in : b_in;
    endfunction
    function automatic logic [33:0] m_atap(int k);
        logic [4:0] m = m_mode(k);
        if (ADEP[k] == 0) return m_asrc(k);
        if (ADEP[k] == 1) return m[0] ? m_asrc(k) : ma2[k];
        return m[0] ? ma1[k] : ma2[k];
    endfunction
    function automatic logic [23:0] m_btap(int k);
        logic [4:0] m = m_mode(k);
        if (BDEP[k] == 0) return m_bsrc(k);
        if (BDEP[k] == 1) return m[4] ? m_bsrc(k) : mb2[k];
        return m[4] ? mb1[k] : mb2[k];
    endfunction
    function automatic logic [27:0] m_pre(int k);
        longint dv, xv, r;
        logic [33:0] at = m_atap(k);
        logic [23:0] bt = m_btap(k);
        dv = longint'($signed(d_in));
        xv = (PUB[k] != 0) ? longint'($signed(bt)) : longint'($signed(at[26:0]));
        r  = m_mode(k)[3] ? dv - xv : dv + xv;
        return r[27:0];
    endfunction

    // Advance the reference by one clock edge using the current inputs.
    task automatic m_step(int k);
        logic [27:0] pre_n = m_pre(k);
        logic [33:0] as = m_asrc(k);
        logic [23:0] bs = m_bsrc(k);
        if (!rst_a_n) begin ma1[k] = '0; ma2[k] = '0; end
        else if (ADEP[k] == 2) begin
            if (ce_a2) ma2[k] = ma1[k];
            if (ce_a1) ma1[k] = as;
        end else if (ADEP[k] == 1 && ce_a2) ma2[k] = as;
        if (!rst_b_n) begin mb1[k] = '0; mb2[k] = '0; end
        else if (BDEP[k] == 2) begin
            if (ce_b2) mb2[k] = mb1[k];
            if (ce_b1) mb1[k] = bs;
        end else if (BDEP[k] == 1 && ce_b2) mb2[k] = bs;
        if (!rst_mode_n) mmode[k] = '0;
        else if (ce_mode) mmode[k] = mode_in;
        if (!rst_ad_n) mad[k] = '0;
        else if (ce_ad) mad[k] = pre_n;
    endtask

    task automatic chk(int k, string tag, logic [33:0] got, logic [33:0] exp);
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s,%s cfg%0d got %h expected %h at %0t", phase, tag, k, got, exp, $time);
        end
    endtask

    // Compare every output of both instances against the reference.
    task automatic compare_all();
        for (int k = 0; k < NCFG; k++) begin
            logic [33:0] ac = (ADEP[k] == 0) ? m_asrc(k) : ma2[k];
            logic [23:0] bc = (BDEP[k] == 0) ? m_bsrc(k) : mb2[k];
            logic [27:0] ad = (AREG[k] != 0) ? mad[k] : m_pre(k);
            n_vec++;
            chk(k, "R3,R5,R7,R8 a_mult", o_amul[k], m_atap(k));
            chk(k, "R4,R5,R7 b_mult", 34'(o_bmul[k]), 34'(m_btap(k)));
            chk(k, "R6,R3 a_casc", o_acas[k], ac);
            chk(k, "R6,R4 b_casc", 34'(o_bcas[k]), 34'(bc));
            chk(k, "R1,R2,R9 ad", 34'(o_ad[k]), 34'(ad));
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        for (int k = 0; k < NCFG; k++) m_step(k);
        @(negedge clk);
        compare_all();
    endtask

    task automatic rand_data();
        d_in      = 27'($urandom());
        a_in      = 34'({$urandom(), $urandom()});
        a_casc_in = 34'({$urandom(), $urandom()});
        b_in      = 24'($urandom());
        b_casc_in = 24'($urandom());
        mode_in   = 5'($urandom());
    endtask

    task automatic all_ce(logic v);
        {ce_a1, ce_a2, ce_b1, ce_b2, ce_mode, ce_ad} = {6{v}};
    endtask

    initial begin
        rand_data();
        // R10: reset state after three cycles with every reset low.
        repeat (3) cycle();
        {rst_a_n, rst_b_n, rst_mode_n, rst_ad_n} = 4'hF;
        all_ce(1'b1);
        // R1: extreme sums, add then signed subtract, held long enough to flush.
        phase = "R1";
        d_in = 27'h3FFFFFF; a_in = 34'h3FFFFFF; b_casc_in = 24'h7FFFFF; b_in = 24'h7FFFFF;
        a_casc_in = 34'h3FFFFFF; mode_in = 5'b00000;
        repeat (5) cycle();
        d_in = 27'h4000000; mode_in = 5'b01000;
        repeat (5) cycle();
        mode_in = 5'b11001;
        repeat (5) cycle();
        // R3: random data with enables dropping at random, mode flipping.
        phase = "R3";
        for (int i = 0; i < 3000; i++) begin
            rand_data();
            {ce_a1, ce_a2, ce_b1, ce_b2, ce_mode, ce_ad} = 6'($urandom() | $urandom());
            cycle();
        end
        // R11: all enables low, data keeps moving.
        phase = "R11";
        all_ce(1'b0);
        for (int i = 0; i < 200; i++) begin rand_data(); cycle(); end
        // R10: each reset pulsed on its own.
        phase = "R10";
        all_ce(1'b1);
        for (int i = 0; i < 400; i++) begin
            rand_data();
            {rst_a_n, rst_b_n, rst_mode_n, rst_ad_n} = 4'hF;
            if ($urandom_range(0, 3) == 0) begin
                case ($urandom_range(0, 3))
                    0: rst_a_n = 1'b0;
                    1: rst_b_n = 1'b0;
                    2: rst_mode_n = 1'b0;
                    default: rst_ad_n = 1'b0;
                endcase
            end
            cycle();
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule